// File: doc/BRIEF.md
# I/O Window Decoder with Cycle Sizing

This block compares each host I/O address against two programmable address windows that belong to one card socket. When an enabled window contains the address and the host is not running a DMA cycle, the block selects the card and drives the card-enable strobe. It also tells the host how the cycle should be run: as a 16-bit or an 8-bit transfer, with no added wait, or with one extra wait state.

Each window has its own small control nibble. That nibble picks where the 16-bit indication comes from: the window's fixed data-size bit, or the live 16-bit request line from the card. It also holds the zero-wait and extra-wait options. Software programs the windows through a byte-wide indexed register port. All outputs are combinational from the address inputs and the stored configuration. Sequencing of the bus cycle belongs to a neighbouring block.

Top module: `iowd_top`

## Requirements
- R1: After synchronous reset, every configuration byte reads back 0, no window hits, `card_en_n`, `iocs16_n` and `nows_n` are 1, and `wait_cnt` is 0.
- R2: A window hits when its enable bit is set, `aen` is 0, and start <= address <= stop, comparing all 16 bits. A window whose start equals its stop hits on exactly that one address. A disabled window never hits. `io_hit` is 1 and `card_en_n` is 0 exactly when some window hits.
- R3: While `aen` is 1, no window hits, whatever the configuration.
- R4: When both windows hit, window 0 is chosen: `win_sel` is 0 and the control nibble of window 0 governs the sizing outputs.
- R5: In the control nibble, bit 0 is the data size (1 = 16-bit) and bit 1 is the source (1 = card line). With the source bit at 0, `iocs16_n` is the inverse of the data-size bit of the chosen window.
- R6: With the source bit and the data-size bit both at 1, `iocs16_n` equals `card_iois16_n`.
- R7: With the data-size bit at 0, `iocs16_n` is 1 whatever the value of `card_iois16_n`.
- R8: Bit 3 of the nibble is the extra-wait bit. When the chosen cycle is 16-bit and that bit is 1, `wait_cnt` is 1. Otherwise it is 0.
- R9: Bit 2 of the nibble is the zero-wait bit. When the chosen cycle is 8-bit and that bit is 1, `nows_n` is 0. In all other cases it is 1.
- R10: Register indices: window w start low/high at 4w and 4w+1, stop low/high at 4w+2 and 4w+3, the control byte at 8 (window 0 in bits 3:0, window 1 in bits 7:4), and the enable byte at 9 (bit w enables window w). Each index reads back what was written to it. Unmapped indices read 0 and ignore writes.
- R11: With no hit, `iocs16_n` and `nows_n` are 1, `wait_cnt` is 0 and `win_sel` is 0, whatever the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_idx | input | 5 | Configuration register index |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Read-back data of the register at `reg_idx` |
| io_addr | input | 16 | Host I/O address |
| aen | input | 1 | DMA address enable; high during DMA cycles |
| card_iois16_n | input | 1 | Card's active-low 16-bit port request |
| io_hit | output | 1 | An enabled window contains the address |
| win_sel | output | 1 | Index of the chosen window |
| card_en_n | output | 1 | Active-low card enable |
| iocs16_n | output | 1 | Active-low 16-bit cycle indication to the host |
| nows_n | output | 1 | Active-low no-wait-state indication to the host |
| wait_cnt | output | 2 | Number of extra wait states requested |

## Verification
The bench sweeps every control byte, every combination of enables, both levels of `aen` and of the card's 16-bit line, over addresses at and around the edges of two overlapping windows. A comparison that is exclusive at either end, or that ignores the upper address byte, would miss the boundary addresses or hit far outside the window. A wrong priority would take the sizing from window 1 in the overlap. Letting the card line act while the window is set to 8 bits would claim a 16-bit cycle. A missing DMA qualifier would select the card during DMA. The one-address window and the full-range window check the degenerate and widest comparisons, and read-back checks the index map.

// File: rtl/iowd_pkg.sv
package iowd_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int REGS_PER_WIN = 2 * ADDR_BYTES;

    // Per-window control nibble, bit 3 down to bit 0.
    typedef struct packed {
        logic wait1;    // bit 3: one extra wait on 16-bit cycles
        logic zws;      // bit 2: zero-wait on 8-bit cycles
        logic src_card; // bit 1: 16-bit indication taken from the card line
        logic size16;   // bit 0: 16-bit data path
    } win_ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_range_t;

    typedef struct packed {
        logic is16;
        logic nows;
        logic wait1;
    } cyc_size_t;

    function automatic logic addr_inside(input logic [ADDR_W-1:0] a,
                                         input win_range_t r);
        return (a >= r.lo) && (a <= r.hi);
    endfunction

    function automatic cyc_size_t size_cycle(input win_ctrl_t c,
                                             input logic card_req16);
        cyc_size_t s;
        s.is16  = c.size16 & (c.src_card ? card_req16 : 1'b1);
        s.nows  = ~s.is16 & c.zws;
        s.wait1 = s.is16 & c.wait1;
        return s;
    endfunction

endpackage

// File: rtl/iowd_regs.sv
module iowd_regs
    import iowd_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [BYTE_W-1:0]             wdata,
    output logic [BYTE_W-1:0]             rdata,
    output win_range_t [NUM_WIN-1:0]      ranges,
    output win_ctrl_t  [NUM_WIN-1:0]      ctrls,
    output logic [NUM_WIN-1:0]            enables
);
    localparam int NIBS_PER_BYTE = BYTE_W / NIB_W;
    localparam int CTRL_BYTES    = (NUM_WIN + NIBS_PER_BYTE - 1) / NIBS_PER_BYTE;
    localparam int CTRL_BASE     = NUM_WIN * REGS_PER_WIN;
    localparam int EN_IDX        = CTRL_BASE + CTRL_BYTES;

    logic [NUM_WIN-1:0][ADDR_W-1:0]    start_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0]    stop_q;
    logic [CTRL_BYTES-1:0][BYTE_W-1:0] ctrl_q;
    logic [NUM_WIN-1:0]                en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            stop_q  <= '0;
            ctrl_q  <= '0;
            en_q    <= '0;
        end else if (we) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                for (int b = 0; b < ADDR_BYTES; b++) begin
                    if (idx == IDX_W'(w * REGS_PER_WIN + b))
                        start_q[w][b*BYTE_W +: BYTE_W] <= wdata;
                    if (idx == IDX_W'(w * REGS_PER_WIN + ADDR_BYTES + b))
                        stop_q[w][b*BYTE_W +: BYTE_W] <= wdata;
                end
            end
            for (int c = 0; c < CTRL_BYTES; c++) begin
                if (idx == IDX_W'(CTRL_BASE + c))
                    ctrl_q[c] <= wdata;
            end
            if (idx == IDX_W'(EN_IDX))
                en_q <= wdata[NUM_WIN-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (idx == IDX_W'(w * REGS_PER_WIN + b))
                    rdata = start_q[w][b*BYTE_W +: BYTE_W];
                if (idx == IDX_W'(w * REGS_PER_WIN + ADDR_BYTES + b))
                    rdata = stop_q[w][b*BYTE_W +: BYTE_W];
            end
        end
        for (int c = 0; c < CTRL_BYTES; c++) begin
            if (idx == IDX_W'(CTRL_BASE + c))
                rdata = ctrl_q[c];
        end
        if (idx == IDX_W'(EN_IDX)) begin
            for (int w = 0; w < NUM_WIN; w++)
                rdata[w] = en_q[w];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_unpack
        assign ranges[w].lo = start_q[w];
        assign ranges[w].hi = stop_q[w];
        assign ctrls[w]     = win_ctrl_t'(ctrl_q[w / NIBS_PER_BYTE][(w % NIBS_PER_BYTE)*NIB_W +: NIB_W]);
    end

    assign enables = en_q;

endmodule

// File: rtl/iowd_win_match.sv
module iowd_win_match
    import iowd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              aen,
    input  logic              enable,
    input  win_range_t        range,
    output logic              hit
);
    always_comb begin
        hit = enable & ~aen & addr_inside(addr, range);
    end
endmodule

// File: rtl/iowd_size_sel.sv
module iowd_size_sel
    import iowd_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int SEL_W   = 1,
    parameter int WAIT_W  = 2
) (
    input  logic [NUM_WIN-1:0]       hits,
    input  win_ctrl_t [NUM_WIN-1:0]  ctrls,
    input  logic                     card_iois16_n,
    output logic                     any_hit,
    output logic [SEL_W-1:0]         sel,
    output cyc_size_t                size,
    output logic [WAIT_W-1:0]        wait_cnt
);
    win_ctrl_t chosen;

    // Lowest-numbered hitting window wins: scan downward so it is applied last.
    always_comb begin
        any_hit = 1'b0;
        sel     = '0;
        chosen  = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits[w]) begin
                any_hit = 1'b1;
                sel     = SEL_W'(w);
                chosen  = ctrls[w];
            end
        end
        size = any_hit ? size_cycle(chosen, ~card_iois16_n) : '0;
        wait_cnt = size.wait1 ? WAIT_W'(1) : '0;
    end
endmodule

// File: rtl/iowd_top.sv
module iowd_top
    import iowd_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 5,
    parameter int WAIT_W  = 2,
    localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [15:0]        io_addr,
    input  logic               aen,
    input  logic               card_iois16_n,
    output logic               io_hit,
    output logic [SEL_W-1:0]   win_sel,
    output logic               card_en_n,
    output logic               iocs16_n,
    output logic               nows_n,
    output logic [WAIT_W-1:0]  wait_cnt
);
    win_range_t [NUM_WIN-1:0] ranges;
    win_ctrl_t  [NUM_WIN-1:0] ctrls;
    logic       [NUM_WIN-1:0] enables;
    logic       [NUM_WIN-1:0] hits;
    cyc_size_t                size;
    logic                     any_hit;

    iowd_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .idx     (reg_idx),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ranges  (ranges),
        .ctrls   (ctrls),
        .enables (enables)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        iowd_win_match u_match (
            .addr   (io_addr),
            .aen    (aen),
            .enable (enables[w]),
            .range  (ranges[w]),
            .hit    (hits[w])
        );
    end

    iowd_size_sel #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W), .WAIT_W(WAIT_W)) u_size (
        .hits          (hits),
        .ctrls         (ctrls),
        .card_iois16_n (card_iois16_n),
        .any_hit       (any_hit),
        .sel           (win_sel),
        .size          (size),
        .wait_cnt      (wait_cnt)
    );

    assign io_hit    = any_hit;
    assign card_en_n = ~any_hit;
    assign iocs16_n  = ~size.is16;
    assign nows_n    = ~size.nows;

endmodule

// File: rtl/iowd_checker.sv
module iowd_checker #(
    parameter int IDX_W  = 5,
    parameter int SEL_W  = 1,
    parameter int WAIT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [15:0]       io_addr,
    input logic              aen,
    input logic              card_iois16_n,
    input logic              io_hit,
    input logic [SEL_W-1:0]  win_sel,
    input logic              card_en_n,
    input logic              iocs16_n,
    input logic              nows_n,
    input logic [WAIT_W-1:0] wait_cnt
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!io_hit && card_en_n && iocs16_n && nows_n && wait_cnt == '0));

    assert_hit_stable_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!reg_we) && $stable(io_addr) && $stable(aen)) |-> $stable(io_hit));

    assert_dma_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
        aen |-> (!io_hit && card_en_n));

    assert_nows_only_8bit_R9: assert property (@(posedge clk) disable iff (rst)
        !nows_n |-> (iocs16_n && io_hit));

    assert_wait_only_16bit_R8: assert property (@(posedge clk) disable iff (rst)
        (wait_cnt != '0) |-> !iocs16_n);

    assert_idle_outputs_R11: assert property (@(posedge clk) disable iff (rst)
        !io_hit |-> (iocs16_n && nows_n && wait_cnt == '0 && win_sel == '0));

    assert_card_line_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && $past(!reg_we) && $stable(io_addr) && $stable(aen) && io_hit
         && iocs16_n && $past(iocs16_n)) |-> $stable(win_sel));
endmodule

bind iowd_top iowd_checker #(.IDX_W(IDX_W), .SEL_W(SEL_W), .WAIT_W(WAIT_W)) u_iowd_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_we        (reg_we),
    .io_addr       (io_addr),
    .aen           (aen),
    .card_iois16_n (card_iois16_n),
    .io_hit        (io_hit),
    .win_sel       (win_sel),
    .card_en_n     (card_en_n),
    .iocs16_n      (iocs16_n),
    .nows_n        (nows_n),
    .wait_cnt      (wait_cnt)
);

// File: tb/test_iowd_top.sv
module test_iowd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] io_addr = '0;
    logic        aen = 1'b0;
    logic        card_iois16_n = 1'b1;
    logic        io_hit;
    logic [0:0]  win_sel;
    logic        card_en_n;
    logic        iocs16_n;
    logic        nows_n;
    logic [1:0]  wait_cnt;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iowd_top i_iowd_top (
        .clk (clk), .rst (rst), .reg_we (reg_we), .reg_idx (reg_idx),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .io_addr (io_addr),
        .aen (aen), .card_iois16_n (card_iois16_n), .io_hit (io_hit),
        .win_sel (win_sel), .card_en_n (card_en_n), .iocs16_n (iocs16_n),
        .nows_n (nows_n), .wait_cnt (wait_cnt)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h (addr=%04h aen=%0b iois16_n=%0b)",
                     tag, got, exp, io_addr, aen, card_iois16_n);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_win(input int w, input logic [15:0] lo, input logic [15:0] hi);
        wr(5'(4*w),     lo[7:0]);
        wr(5'(4*w + 1), lo[15:8]);
        wr(5'(4*w + 2), hi[7:0]);
        wr(5'(4*w + 3), hi[15:8]);
    endtask

    // Expected {hit, sel, card_en_n, iocs16_n, nows_n, wait_cnt[1:0]}
    function automatic logic [6:0] model(input logic [15:0] a, input logic dma,
                                         input logic io_n, input logic [1:0] en,
                                         input logic [7:0] ctl,
                                         input logic [15:0] s0, input logic [15:0] e0,
                                         input logic [15:0] s1, input logic [15:0] e1);
        logic h0, h1, hit, sel, is16, nws, wt;
        logic [3:0] nib;
        h0 = en[0] && !dma && s0 <= a && a <= e0;
        h1 = en[1] && !dma && s1 <= a && a <= e1;
        hit = h0 | h1;
        sel = hit && !h0;
        nib = sel ? ctl[7:4] : ctl[3:0];
        is16 = hit && nib[0] && (nib[1] ? !io_n : 1'b1);
        nws  = hit && !is16 && nib[2];
        wt   = is16 && nib[3];
        return {hit, sel, !hit, !is16, !nws, 1'b0, wt};
    endfunction

    function automatic string pick_tag(input logic [15:0] a, input logic dma,
                                       input logic io_n, input logic [1:0] en,
                                       input logic [7:0] ctl,
                                       input logic [15:0] s0, input logic [15:0] e0,
                                       input logic [15:0] s1, input logic [15:0] e1);
        logic h0, h1;
        logic [3:0] nib;
        logic is16;
        h0 = en[0] && s0 <= a && a <= e0;
        h1 = en[1] && s1 <= a && a <= e1;
        nib = h0 ? ctl[3:0] : ctl[7:4];
        is16 = nib[0] && (nib[1] ? !io_n : 1'b1);
        if (dma) return "R3";
        if (!(h0 || h1)) return "R11";
        if (h0 && h1) return "R4";
        if (is16 && nib[3]) return "R8";
        if (!is16 && nib[2]) return "R9";
        if (nib[1] && nib[0]) return "R6";
        if (nib[1]) return "R7";
        return "R5";
    endfunction

    task automatic probe(input string tag, input logic [15:0] a, input logic dma,
                         input logic io_n, input logic [6:0] exp);
        @(negedge clk);
        io_addr = a; aen = dma; card_iois16_n = io_n;
        #1;
        check(tag, {io_hit, win_sel, card_en_n, iocs16_n, nows_n, wait_cnt}, 32'(exp));
    endtask

    localparam logic [15:0] S0 = 16'h0300, E0 = 16'h031F;
    localparam logic [15:0] S1 = 16'h0310, E1 = 16'h03FF;

    initial begin
        logic [15:0] addrs [10];
        addrs = '{16'h02FF, 16'h0300, 16'h0301, 16'h030F, 16'h0310,
                  16'h031F, 16'h0320, 16'h03FF, 16'h0400, 16'h1310};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 outputs", {io_hit, card_en_n, iocs16_n, nows_n, wait_cnt}, {1'b0, 1'b1, 1'b1, 1'b1, 2'b00});
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); reg_idx = 5'(i); #1;
            check("R1 readback", reg_rdata, 8'h00);
        end

        // R10: register map and read-back
        set_win(0, S0, E0);
        set_win(1, S1, E1);
        wr(5'd8, 8'hA5);
        wr(5'd9, 8'h03);
        wr(5'd20, 8'hFF);
        begin
            logic [7:0] expv [10];
            expv = '{8'h00, 8'h03, 8'h1F, 8'h03, 8'h10, 8'h03, 8'hFF, 8'h03, 8'hA5, 8'h03};
            for (int i = 0; i < 10; i++) begin
                @(negedge clk); reg_idx = 5'(i); #1;
                check("R10 readback", reg_rdata, expv[i]);
            end
            @(negedge clk); reg_idx = 5'd20; #1;
            check("R10 unmapped", reg_rdata, 8'h00);
        end

        // Sweep of control byte, enables, aen and card line over boundary addresses
        for (int c = 0; c < 256; c++) begin
            wr(5'd8, 8'(c));
            for (int e = 0; e < 4; e++) begin
                wr(5'd9, 8'(e));
                for (int d = 0; d < 2; d++) begin
                    for (int n = 0; n < 2; n++) begin
                        for (int k = 0; k < 10; k++) begin
                            probe(pick_tag(addrs[k], d[0], n[0], 2'(e), 8'(c), S0, E0, S1, E1),
                                  addrs[k], d[0], n[0],
                                  model(addrs[k], d[0], n[0], 2'(e), 8'(c), S0, E0, S1, E1));
                        end
                    end
                end
            end
        end

        // R2: one-address window on window 1, full-range window 0 disabled
        set_win(1, 16'hABCD, 16'hABCD);
        set_win(0, 16'h0000, 16'hFFFF);
        wr(5'd8, 8'h10);
        wr(5'd9, 8'h02);
        probe("R2 single below", 16'hABCC, 1'b0, 1'b1, model(16'hABCC, 1'b0, 1'b1, 2'b10, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));
        probe("R2 single hit",   16'hABCD, 1'b0, 1'b1, model(16'hABCD, 1'b0, 1'b1, 2'b10, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));
        probe("R2 single above", 16'hABCE, 1'b0, 1'b1, model(16'hABCE, 1'b0, 1'b1, 2'b10, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));
        probe("R2 high byte",    16'hBBCD, 1'b0, 1'b1, model(16'hBBCD, 1'b0, 1'b1, 2'b10, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));
        probe("R2 disabled",     16'h0000, 1'b0, 1'b1, model(16'h0000, 1'b0, 1'b1, 2'b10, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));
        wr(5'd9, 8'h01);
        probe("R2 full low",  16'h0000, 1'b0, 1'b1, model(16'h0000, 1'b0, 1'b1, 2'b01, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));
        probe("R2 full high", 16'hFFFF, 1'b0, 1'b1, model(16'hFFFF, 1'b0, 1'b1, 2'b01, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));
        probe("R3 full dma",  16'hFFFF, 1'b1, 1'b1, model(16'hFFFF, 1'b1, 1'b1, 2'b01, 8'h10, 16'h0000, 16'hFFFF, 16'hABCD, 16'hABCD));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule